// File: doc/BRIEF.md
# Pixel Clock Post-Scaler with Output Blanking

This block turns a fast source clock into a differential pixel-clock pair. It also produces two slower strobes: a LOAD strobe from a programmable divider, and a second divided output that counts LOAD. The fast source is delivered as a stream of single-cycle tick pulses on the system clock. Each tick marks one edge (one half-period) of the source. A reference tick input can take the place of the PLL tick input. Because the source arrives as ticks, the block is a single synchronous clock domain with no clock multiplexing.

A two-bit mode field selects how the pixel pair is produced. Three codes scale the source by 1, 2 or 4. The fourth code hands both the pixel pair and LOAD to register bits, so software can step the outputs by hand. A blanking bit parks the pair at fixed levels. After the bit is cleared, the pair resumes only on a LOAD rising edge. A jam bit holds every counter at zero.

The control registers are loaded through a plain parallel write port. Writes always complete, so that port has no handshake or back-pressure.

Top module: `pixclk_postscaler`

## Requirements
- R1: With mode 00 selected, `clk_p` toggles on every source tick, so the pixel pair reproduces the source clock.
- R2: Mode 01 toggles `clk_p` every 2 ticks and mode 10 every 4 ticks (divide by 2 and by 4).
- R3: In modes 00, 01 and 10, `load` is high for one pixel-clock period out of every N1 pixel periods, where N1 is the value at address 1. Values 0 and 1 act as 2.
- R4: `n2_out` is high for one LOAD period out of every N2 rising edges of `load`, where N2 is the value at address 2. Values 0 and 1 act as 2.
- R5: Mode 11 is the auxiliary mode. Control bit 2 drives `clk_p`, control bit 3 drives `load` (and through it the second divider), and source ticks have no effect on the pair.
- R6: While the blanking bit (control bit 4) is 1, `clk_p` is 1 and `clk_n` is 0 from the cycle after it is set. LOAD and the dividers keep running.
- R7: After the blanking bit is cleared, the pair stays parked until a rising edge of `load`. The pair is released in the cycle after that edge.
- R8: When control bit 6 is 1, `ref_tick` clocks the post-scaler and `pll_tick` is ignored.
- R9: While the jam bit (control bit 5) is 1, the post-scaler phase and both divider counters are held at zero, and `clk_p`, `load` and `n2_out` are low. The block restarts from zero when the bit is cleared.
- R10: `clk_n` is always the opposite level of `clk_p`.
- R11: An active-low asynchronous `rst_n` clears all registers. This gives divide-by-1 with N1 = N2 = 2, no blanking, no jam and no auxiliary drive: `clk_p`=0, `clk_n`=1, `load`=0, `n2_out`=0.
- R12: A new mode takes effect only when the three-bit tick phase counter wraps to zero, or under jam. As a result, no pixel-clock level is cut short.
- R13: Address 0 is the control register: mode in bits 1:0, auxiliary pixel bit 2, auxiliary load bit 3, blanking bit 4, jam bit 5, reference select bit 6. Addresses 1 and 2 hold N1 and N2. A write to address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick | input | 1 | One pulse per edge of the PLL clock |
| ref_tick | input | 1 | One pulse per edge of the reference clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DIV_W | Register write data |
| clk_p | output | 1 | Pixel clock, true side |
| clk_n | output | 1 | Pixel clock, complement side |
| load | output | 1 | LOAD strobe from the first divider |
| n2_out | output | 1 | Second divider output |

## Verification
The bench changes the mode in the middle of a divide-by-1 run. A scaler that switched at once would emit a three-tick level, and the bench flags any pixel run that is not 1 or 4 ticks long. It clears blanking while the source is idle and expects the pair to stay parked. It then watches for release exactly one cycle after the first LOAD rise; a design that released at once, or on a pixel edge, would unpark early. Ratio fields of 0 and 1 are checked for acting as 2, and a divider that treated them literally would hold LOAD high or count wrongly. Reference selection with `pll_tick` held high, and jam with ticks running, show whether the wrong source or a counter leaks through.

// File: rtl/pixclk_pkg.sv
`timescale 1ns/1ps
package pixclk_pkg;

  typedef enum logic [1:0] {
    MODE_PASS    = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_AUX     = 2'b11
  } scale_mode_e;

  // Control word layout: the field order sets the bit positions.
  typedef struct packed {
    logic        ref_sel;   // bit 6
    logic        jam;       // bit 5
    logic        blank;     // bit 4
    logic        aux_load;  // bit 3
    logic        aux_pix;   // bit 2
    scale_mode_e mode;      // bits 1:0
  } ctrl_t;

  localparam int CTRL_W  = $bits(ctrl_t);
  localparam int ADDR_W  = 2;
  localparam int PHASE_W = 3;  // wraps every 8 ticks: one divide-by-4 period

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_N1   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_N2   = 2'd2;

endpackage

// File: rtl/pixclk_regs.sv
`timescale 1ns/1ps
module pixclk_regs
  import pixclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DIV_W-1:0]  wr_data,
  output ctrl_t             ctrl_q,
  output logic [DIV_W-1:0]  n1_q,
  output logic [DIV_W-1:0]  n2_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      n1_q   <= '0;
      n2_q   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_N1:   n1_q   <= wr_data;
        ADDR_N2:   n2_q   <= wr_data;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/pixclk_scaler.sv
`timescale 1ns/1ps
module pixclk_scaler
  import pixclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               jam,
  input  scale_mode_e        req_mode,
  output logic               pix,
  output logic               pix_fall,
  output scale_mode_e        act_mode,
  output logic [PHASE_W-1:0] phase
);

  logic [PHASE_W-1:0] phase_nxt;
  logic               pix_nxt;

  // Each scale mode taps one bit of the tick phase counter.
  always_comb begin
    phase_nxt = phase + 1'b1;
    case (act_mode)
      MODE_PASS:    pix_nxt = phase_nxt[0];
      MODE_HALF:    pix_nxt = phase_nxt[1];
      MODE_QUARTER: pix_nxt = phase_nxt[2];
      default:      pix_nxt = 1'b0;
    endcase
  end

  assign pix_fall = tick & ~jam & pix & ~pix_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      pix      <= 1'b0;
      act_mode <= MODE_PASS;
    end else if (jam) begin
      phase    <= '0;
      pix      <= 1'b0;
      act_mode <= req_mode;
    end else if (tick) begin
      phase <= phase_nxt;
      pix   <= pix_nxt;
      // At the wrap every tap is low, so swapping modes here is glitch free.
      if (phase_nxt == '0) act_mode <= req_mode;
    end
  end

endmodule

// File: rtl/pixclk_div.sv
`timescale 1ns/1ps
module pixclk_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] ratio,
  output logic         pulse
);

  localparam logic [W-1:0] MIN_RATIO = W'(2);

  logic [W-1:0] eff;
  logic [W-1:0] last;
  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    eff     = (ratio < MIN_RATIO) ? MIN_RATIO : ratio;
    last    = eff - 1'b1;
    // ">=" also recovers when the ratio shrinks below the current count.
    cnt_nxt = (cnt >= last) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (step) begin
      cnt   <= cnt_nxt;
      pulse <= (cnt_nxt == last);
    end
  end

endmodule

// File: rtl/pixclk_postscaler.sv
`timescale 1ns/1ps
module pixclk_postscaler
  import pixclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_tick,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DIV_W-1:0]  wr_data,
  output logic              clk_p,
  output logic              clk_n,
  output logic              load,
  output logic              n2_out
);

  ctrl_t              ctrl_q;
  logic [DIV_W-1:0]   n1_ratio;
  logic [DIV_W-1:0]   n2_ratio;
  logic               src_tick;
  logic               pix;
  logic               pix_fall;
  scale_mode_e        act_mode;
  logic [PHASE_W-1:0] phase;
  logic               n1_pulse;
  logic               load_d;
  logic               load_rise;
  logic               held_q;
  logic               aux_act;
  logic               pix_sel;

  pixclk_regs #(.DIV_W(DIV_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .n1_q    (n1_ratio),
    .n2_q    (n2_ratio)
  );

  assign src_tick = ctrl_q.ref_sel ? ref_tick : pll_tick;

  pixclk_scaler u_scaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (src_tick),
    .jam      (ctrl_q.jam),
    .req_mode (ctrl_q.mode),
    .pix      (pix),
    .pix_fall (pix_fall),
    .act_mode (act_mode),
    .phase    (phase)
  );

  pixclk_div #(.W(DIV_W)) u_div_n1 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_q.jam),
    .step  (pix_fall),
    .ratio (n1_ratio),
    .pulse (n1_pulse)
  );

  assign aux_act   = (act_mode == MODE_AUX);
  assign load      = aux_act ? ctrl_q.aux_load : n1_pulse;
  assign pix_sel   = aux_act ? ctrl_q.aux_pix  : pix;
  assign load_rise = load & ~load_d;

  pixclk_div #(.W(DIV_W)) u_div_n2 (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_q.jam),
    .step  (load_rise),
    .ratio (n2_ratio),
    .pulse (n2_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_d <= 1'b0;
      held_q <= 1'b0;
    end else begin
      load_d <= load;
      if (ctrl_q.blank)   held_q <= 1'b1;
      else if (load_rise) held_q <= 1'b0;
    end
  end

  assign clk_p = held_q | pix_sel;
  assign clk_n = ~held_q & ~pix_sel;

endmodule

// File: rtl/pixclk_postscaler_chk.sv
`timescale 1ns/1ps
module pixclk_postscaler_chk
  import pixclk_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               clk_p,
  input logic               clk_n,
  input logic               n2_out,
  input logic               blank_q,
  input logic               jam_q,
  input logic               ref_sel_q,
  input logic               ref_tick,
  input logic               held_q,
  input logic               load_rise,
  input logic [1:0]         act_mode,
  input logic [PHASE_W-1:0] phase
);

  AST_PAIR_OPPOSED: assert property (@(posedge clk) disable iff (!rst_n)
    clk_p != clk_n) else $error("pair levels equal"); // R10

  AST_BLANK_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    blank_q |=> (clk_p && !clk_n)) else $error("blank not parked"); // R6

  AST_RELEASE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held_q) |-> $past(load_rise)) else $error("release off LOAD"); // R7

  AST_JAM_CLEARS_N2: assert property (@(posedge clk) disable iff (!rst_n)
    jam_q |=> !n2_out) else $error("jam left n2 high"); // R9

  AST_REF_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel_q && !ref_tick && !jam_q) |=> $stable(phase)) else $error("pll leaked"); // R8

  AST_MODE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mode) |-> ($past(jam_q) || ($past(phase) == {PHASE_W{1'b1}})))
    else $error("mode changed mid period"); // R12

endmodule

bind pixclk_postscaler pixclk_postscaler_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_p     (clk_p),
  .clk_n     (clk_n),
  .n2_out    (n2_out),
  .blank_q   (ctrl_q.blank),
  .jam_q     (ctrl_q.jam),
  .ref_sel_q (ctrl_q.ref_sel),
  .ref_tick  (ref_tick),
  .held_q    (held_q),
  .load_rise (load_rise),
  .act_mode  (act_mode),
  .phase     (phase)
);

// File: tb/pixclk_postscaler_tb.sv
`timescale 1ns/1ps
module pixclk_postscaler_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_tick = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       clk_p, clk_n, load, n2_out;

  pixclk_postscaler #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .ref_tick(ref_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_p(clk_p), .clk_n(clk_n), .load(load), .n2_out(n2_out)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    int mode; int n1; int n2; int ticks; int e_pix; int e_load; int e_n2;
  } vec_t;

  // Expected rising-edge counts of clk_p, load and n2_out after the run.
  localparam vec_t VEC [5] = '{
    '{0, 3, 2, 40, 20, 7, 4},
    '{1, 2, 3, 48, 12, 6, 2},
    '{2, 4, 2, 64,  8, 2, 1},
    '{0, 0, 1, 20, 10, 5, 3},
    '{1, 5, 2, 80, 20, 4, 2}
  };

  int   n_chk = 0, n_fail = 0;
  int   r_pix, r_load, r_n2, pair_err;
  logic pv_p, pv_l, pv_n;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    r_pix = 0; r_load = 0; r_n2 = 0; pair_err = 0;
    pv_p = clk_p; pv_l = load; pv_n = n2_out;
  endtask

  task automatic sample();
    if (clk_p && !pv_p) r_pix++;
    if (load && !pv_l) r_load++;
    if (n2_out && !pv_n) r_n2++;
    if (clk_p == clk_n) pair_err++;
    pv_p = clk_p; pv_l = load; pv_n = n2_out;
  endtask

  // Drive at a falling edge, let one rising edge act, sample at the next falling edge.
  task automatic cyc(input logic pt, input logic rt, input logic we,
                     input logic [1:0] a, input logic [7:0] d);
    pll_tick = pt; ref_tick = rt; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    pll_tick = 1'b0; ref_tick = 1'b0; wr_en = 1'b0;
    sample();
  endtask

  function automatic logic [7:0] ctl(input int mode, input bit ap, input bit al,
                                     input bit bl, input bit jm, input bit rs);
    ctl = {1'b0, rs, jm, bl, al, ap, mode[1:0]};
  endfunction

  task automatic restart(input int mode, input int n1, input int n2, input bit rs);
    cyc(0, 0, 1, 2'd0, ctl(mode, 0, 0, 0, 1, rs));
    cyc(0, 0, 1, 2'd1, n1[7:0]);
    cyc(0, 0, 1, 2'd2, n2[7:0]);
    cyc(0, 0, 1, 2'd0, ctl(mode, 0, 0, 0, 0, rs));
    clear_counts();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad, run, runs4, first_low, seen_at;
    logic last;
    bit first;

    // R11: reset state
    repeat (3) @(negedge clk);
    check(clk_p == 0 && clk_n == 1, "R11 reset pair", {clk_p, clk_n}, 1);
    check(load == 0 && n2_out == 0, "R11 reset strobes", {load, n2_out}, 0);
    rst_n = 1'b1;
    clear_counts();
    // R13: unmapped address ignored; default divide-by-1 (R1)
    cyc(0, 0, 1, 2'd3, 8'hFF);
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (clk_p != ((i % 2) == 0)) bad++;
    end
    check(bad == 0, "R13 addr3 ignored / R1 default toggle", bad, 0);

    // Table of scale modes, ratios and expected edge counts
    foreach (VEC[k]) begin
      restart(VEC[k].mode, VEC[k].n1, VEC[k].n2, 0);
      repeat (VEC[k].ticks) cyc(1, 0, 0, 0, 0);
      repeat (3) cyc(0, 0, 0, 0, 0);
      check(r_pix == VEC[k].e_pix, (VEC[k].mode == 0) ? "R1 pixel edges" : "R2 pixel edges",
            r_pix, VEC[k].e_pix);
      check(r_load == VEC[k].e_load, "R3 load edges", r_load, VEC[k].e_load);
      check(r_n2 == VEC[k].e_n2, "R4 n2 edges", r_n2, VEC[k].e_n2);
      check(pair_err == 0, "R10 complement", pair_err, 0);
    end

    // R5: auxiliary mode
    restart(3, 4, 2, 0);
    repeat (6) cyc(1, 0, 0, 0, 0);
    check(r_pix == 0 && clk_p == 0, "R5 ticks ignored in aux", r_pix, 0);
    cyc(1, 0, 1, 2'd0, ctl(3, 1, 0, 0, 0, 0));
    check(clk_p == 1 && clk_n == 0, "R5 aux pixel bit", clk_p, 1);
    clear_counts();
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0, 1, 2'd0, ctl(3, 1, 1, 0, 0, 0));
      cyc(1, 0, 1, 2'd0, ctl(3, 1, 0, 0, 0, 0));
    end
    repeat (2) cyc(0, 0, 0, 0, 0);
    check(r_load == 4, "R5 aux load bit", r_load, 4);
    check(r_n2 == 2, "R5 R4 n2 from aux load", r_n2, 2);

    // R11: asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1 check(clk_p == 0 && clk_n == 1 && load == 0, "R11 async reset", clk_p, 0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_counts();
    repeat (6) cyc(1, 0, 0, 0, 0);
    check(r_pix == 3, "R11 divide-by-1 after reset", r_pix, 3);

    // R12: mode change waits for the phase wrap
    restart(0, 4, 2, 0);
    repeat (3) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 2'd0, ctl(2, 0, 0, 0, 0, 0));
    last = clk_p; run = 0; first = 1; bad = 0; runs4 = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (clk_p == last) run++;
      else begin
        if (!first && run != 1 && run != 4) bad++;
        if (!first && run == 4) runs4++;
        first = 0; run = 1; last = clk_p;
      end
    end
    check(bad == 0, "R12 no shortened level", bad, 0);
    check(runs4 >= 4, "R12 divide-by-4 reached", runs4, 4);

    // R6 / R7: blanking and synchronized release
    restart(0, 4, 2, 0);
    cyc(1, 0, 1, 2'd0, ctl(0, 0, 0, 1, 0, 0));
    cyc(1, 0, 0, 0, 0);
    clear_counts();
    bad = 0;
    repeat (20) begin
      cyc(1, 0, 0, 0, 0);
      if (!(clk_p && !clk_n)) bad++;
    end
    check(bad == 0, "R6 pair parked", bad, 0);
    check(r_load > 0, "R6 load keeps running", r_load, 1);
    cyc(0, 0, 1, 2'd0, ctl(0, 0, 0, 0, 0, 0));
    bad = 0;
    repeat (5) begin
      cyc(0, 0, 0, 0, 0);
      if (!(clk_p && !clk_n)) bad++;
    end
    check(bad == 0, "R7 parked without load edge", bad, 0);
    clear_counts();
    bad = 0; seen_at = -1; first_low = -1;
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (seen_at < 0) begin
        if (!(clk_p && !clk_n)) bad++;
        if (r_load > 0) seen_at = i;
      end else if (first_low < 0 && !clk_p) first_low = i;
    end
    check(bad == 0 && seen_at >= 0, "R7 held until load edge", bad, 0);
    check(first_low - seen_at == 1 || first_low - seen_at == 2, "R7 release timing",
          first_low - seen_at, 1);

    // R8: reference tick replaces the PLL tick
    restart(0, 4, 2, 1);
    for (int i = 0; i < 30; i++) cyc(1, (i % 3) == 0, 0, 0, 0);
    repeat (2) cyc(1, 0, 0, 0, 0);
    check(r_pix == 5, "R8 reference source", r_pix, 5);

    // R9: jam holds counters at zero
    restart(0, 3, 2, 0);
    repeat (20) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 2'd0, ctl(0, 0, 0, 0, 1, 0));
    bad = 0;
    repeat (11) begin
      cyc(1, 0, 0, 0, 0);
      if (load || n2_out || clk_p) bad++;
    end
    check(bad == 0, "R9 jam holds low", bad, 0);
    cyc(0, 0, 1, 2'd0, ctl(0, 0, 0, 0, 0, 0));
    clear_counts();
    repeat (20) cyc(1, 0, 0, 0, 0);
    repeat (3) cyc(0, 0, 0, 0, 0);
    check(r_pix == 10, "R9 restart pixel", r_pix, 10);
    check(r_load == 3, "R9 restart load", r_load, 3);
    check(r_n2 == 2, "R9 restart n2", r_n2, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule